// File: doc/BRIEF.md
# Character Display RAM Clear and Cursor Controller

This block is the control core of a character display controller. It keeps an 80-byte display data RAM and a RAM address counter. The host programs it through a single register write port: a 4-bit index picks a register and an 8-bit value is written to it. One index writes a character into the RAM at the counter position. Another loads the counter directly. A strobe reads the character at the counter. Every RAM access moves the counter one step, up or down, and the counter wraps at both ends.

A clear command fills every RAM location with the blank code 0xA0. The fill writes one location per clock and raises `busy` for its whole length. When the last location is written, the counter is set to 0. A home command sets the counter to 0 at once and leaves the RAM as it is. The cursor follows the counter. Its shape mode and enable come from the same register that holds the home bit. The blinking modes count a 64-frame cycle using a frame-start pulse from the scan timing, so the blink rate does not depend on the clock rate. The scan logic reads characters through a separate read port that has one cycle of latency.

Top module: `dsp_text_core`

## Requirements
- R1: After a synchronous reset, `cursor_pos` is 0, `busy` is 0, `cursor_vis` is 0, `cursor_style` is 0 and the step direction is up.
- R2: A write with index 4'h9 stores `wr_data` at the counter address. In the same cycle the counter moves one step in the current direction.
- R3: A write with index 4'h3 sets the step direction from `wr_data[0]`: 1 means up and 0 means down. Stepping up from 79 gives 0, and stepping down from 0 gives 79.
- R4: A one-cycle `rd_req` while `wr_en` is low puts the byte at the counter address on `rd_data` after the next clock edge. The counter steps in the same cycle. `rd_data` keeps its value until the next accepted read.
- R5: A write with index 4'h8 loads the counter with `wr_data` when that value is below 80. Values from 80 to 255 leave the counter unchanged.
- R6: A write with index 4'h1 and `wr_data[0]`=1 starts a clear. `busy` is 1 for exactly 80 cycles, starting at the next clock edge. During those cycles every address is filled with 0xA0. `cursor_pos` is 0 when `busy` falls.
- R7: While `busy` is 1, all register writes and `rd_req` are ignored. The counter, the direction, `rd_data` and the RAM contents are not changed by host traffic.
- R8: A write with index 4'h2 loads the cursor enable from bit 2 and the cursor mode from bits 1:0. If bit 3 is 1, the counter also goes to 0 and the RAM is not changed.
- R9: `cursor_pos` always equals the counter. `cursor_vis` is 0 whenever the cursor enable is 0.
- R10: A 6-bit frame count advances by one on each `frame_start` pulse and wraps from 63 to 0. With the cursor enabled, modes 2'b01 and 2'b10 make `cursor_vis` 1 only while the count is below 32. Modes 2'b00 and 2'b11 keep `cursor_vis` at 1. `cursor_vis` follows its inputs with one cycle of delay.
- R11: `scan_data` shows the byte at `scan_addr` one cycle after `scan_addr` is applied. For addresses 80 and above, `scan_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Register index |
| wr_data | input | 8 | Register write value |
| rd_req | input | 1 | Host RAM read strobe |
| rd_data | output | 8 | Byte from the last accepted host read |
| frame_start | input | 1 | One-cycle pulse at the start of each display frame |
| scan_addr | input | 7 | Scan-side character address |
| scan_data | output | 8 | Character at scan_addr, one cycle later |
| busy | output | 1 | Clear fill in progress |
| cursor_pos | output | 7 | Current address counter, which is the cursor position |
| cursor_vis | output | 1 | Cursor drawn in this cycle |
| cursor_style | output | 2 | Selected cursor mode |

## Verification
On every cycle, assertions check the following. The counter stays below 80 and wraps correctly at both ends. The fill runs one address per cycle and ends after the last address. The counter does not move while the fill runs. Home and the end of a clear both leave the counter at 0. The frame count steps only on a pulse. A disabled cursor is never visible. The bench scenarios cover what needs stored data or longer histories: the RAM contents after fills and writes, the values returned by host reads and scan reads, that a direction write during a fill is ignored, and the 32-frame visible and hidden halves of the blink cycle in each mode.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  typedef enum logic [3:0] {
    IDX_FUNC  = 4'h1,
    IDX_CURS  = 4'h2,
    IDX_ENTRY = 4'h3,
    IDX_ADDR  = 4'h8,
    IDX_DATA  = 4'h9
  } reg_idx_e;

  typedef enum logic [1:0] {
    CM_LINE      = 2'b00,
    CM_BLINK     = 2'b01,
    CM_INV_BLINK = 2'b10,
    CM_BLOCK     = 2'b11
  } cur_mode_e;

  localparam logic [7:0] BLANK_CODE = 8'hA0;

  function automatic logic mode_blinks(input logic [1:0] m);
    return (m == CM_BLINK) || (m == CM_INV_BLINK);
  endfunction
endpackage

// File: rtl/dtc_ram.sv
module dtc_ram #(
  parameter int DEPTH = 80,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic          a_re,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (a_re) a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/dtc_addr_ctr.sv
module dtc_addr_ctr #(
  parameter int DEPTH = 80,
  localparam int AW   = $clog2(DEPTH),
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          zero,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_val,
  input  logic          step,
  input  logic          up,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst || zero)   addr <= '0;
    else if (ld_en)    addr <= ld_val;
    else if (step) begin
      if (up) addr <= (addr == LAST) ? '0 : addr + 1'b1;
      else    addr <= (addr == '0) ? LAST : addr - 1'b1;
    end
  end

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
    addr <= LAST); // R3
  AST_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
    (step && up && !zero && !ld_en && addr == LAST) |=> addr == '0); // R3
  AST_WRAP_DN: assert property (@(posedge clk) disable iff (rst)
    (step && !up && !zero && !ld_en && addr == '0) |=> addr == LAST); // R3
endmodule

// File: rtl/dtc_fill_seq.sv
module dtc_fill_seq #(
  parameter int DEPTH = 80,
  localparam int AW   = $clog2(DEPTH),
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          fill_we,
  output logic [AW-1:0] fill_addr,
  output logic          done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      fill_addr <= '0;
    end else if (busy) begin
      if (fill_addr == LAST) busy <= 1'b0;
      fill_addr <= (fill_addr == LAST) ? '0 : fill_addr + 1'b1;
    end else if (start) begin
      busy      <= 1'b1;
      fill_addr <= '0;
    end
  end

  assign fill_we = busy;
  assign done    = busy && (fill_addr == LAST);

  AST_FILL_ENDS: assert property (@(posedge clk) disable iff (rst)
    (busy && fill_addr == LAST) |=> !busy); // R6
  AST_FILL_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (busy && fill_addr != LAST) |=> (busy && fill_addr == AW'($past(fill_addr) + 1))); // R6
  AST_FILL_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> fill_addr == '0); // R6
endmodule

// File: rtl/dtc_cursor.sv
module dtc_cursor #(
  parameter int FW = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_start,
  input  logic       cfg_we,
  input  logic       cfg_en,
  input  logic [1:0] cfg_mode,
  output logic       vis,
  output logic [1:0] style
);
  import dtc_pkg::*;

  logic [FW-1:0] fcnt;
  logic          en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt  <= '0;
      en_q  <= 1'b0;
      style <= CM_LINE;
      vis   <= 1'b0;
    end else begin
      if (frame_start) fcnt <= fcnt + 1'b1;
      if (cfg_we) begin
        en_q  <= cfg_en;
        style <= cfg_mode;
      end
      vis <= en_q && (!mode_blinks(style) || !fcnt[FW-1]);
    end
  end

  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> fcnt == FW'($past(fcnt) + 1)); // R10
  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(fcnt)); // R10
  AST_CURSOR_OFF: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !vis); // R9
endmodule

// File: rtl/dsp_text_core.sv
module dsp_text_core #(
  parameter int DEPTH = 80,
  parameter int DW    = 8,
  parameter int FW    = 6,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [3:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req,
  output logic [DW-1:0] rd_data,
  input  logic          frame_start,
  input  logic [AW-1:0] scan_addr,
  output logic [DW-1:0] scan_data,
  output logic          busy,
  output logic [AW-1:0] cursor_pos,
  output logic          cursor_vis,
  output logic [1:0]    cursor_style
);
  import dtc_pkg::*;

  logic          wr_ok, clear_go, home, addr_ld, data_wr, host_rd, step_up;
  logic          fill_we, fill_done;
  logic [AW-1:0] fill_addr, a_addr;
  logic [DW-1:0] a_wdata, b_rdata;
  logic          scan_ok;

  assign wr_ok    = wr_en && !busy;
  assign clear_go = wr_ok && (wr_idx == IDX_FUNC) && wr_data[0];
  assign home     = wr_ok && (wr_idx == IDX_CURS) && wr_data[3];
  assign addr_ld  = wr_ok && (wr_idx == IDX_ADDR) && (wr_data < DW'(DEPTH));
  assign data_wr  = wr_ok && (wr_idx == IDX_DATA);
  assign host_rd  = rd_req && !wr_en && !busy;

  always_ff @(posedge clk) begin
    if (rst)                                step_up <= 1'b1;
    else if (wr_ok && wr_idx == IDX_ENTRY)  step_up <= wr_data[0];
  end

  dtc_fill_seq #(.DEPTH(DEPTH)) u_fill (
    .clk(clk), .rst(rst), .start(clear_go), .busy(busy),
    .fill_we(fill_we), .fill_addr(fill_addr), .done(fill_done)
  );

  dtc_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
    .clk(clk), .rst(rst), .zero(home || fill_done),
    .ld_en(addr_ld), .ld_val(wr_data[AW-1:0]),
    .step(data_wr || host_rd), .up(step_up), .addr(cursor_pos)
  );

  assign a_addr  = busy ? fill_addr : cursor_pos;
  assign a_wdata = busy ? BLANK_CODE : wr_data;

  dtc_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk(clk), .a_we(fill_we || data_wr), .a_re(host_rd),
    .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(rd_data),
    .b_addr(scan_addr), .b_rdata(b_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) scan_ok <= 1'b0;
    else     scan_ok <= (scan_addr < AW'(DEPTH));
  end
  assign scan_data = scan_ok ? b_rdata : '0;

  dtc_cursor #(.FW(FW)) u_cur (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .cfg_we(wr_ok && wr_idx == IDX_CURS), .cfg_en(wr_data[2]),
    .cfg_mode(wr_data[1:0]), .vis(cursor_vis), .style(cursor_style)
  );

  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (busy && !fill_done) |=> $stable(cursor_pos)); // R7
  AST_CLEAR_HOME: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> cursor_pos == '0); // R6
  AST_HOME_ZERO: assert property (@(posedge clk) disable iff (rst)
    home |=> cursor_pos == '0); // R8
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(rd_data)); // R7
endmodule

// File: tb/sim_dsp_text_core.sv
`timescale 1ns/1ps
module sim_dsp_text_core;
  logic       clk = 0, rst = 1;
  logic       wr_en = 0, rd_req = 0, frame_start = 0;
  logic [3:0] wr_idx = 0;
  logic [7:0] wr_data = 0;
  logic [6:0] scan_addr = 0;
  logic [7:0] rd_data, scan_data;
  logic       busy, cursor_vis;
  logic [6:0] cursor_pos;
  logic [1:0] cursor_style;

  int total = 0, bad = 0;
  int mm [80];
  int m_addr = 0, m_fc = 0;
  bit m_up = 1, m_en = 0;
  int m_mode = 0;

  always #5 clk = ~clk;

  dsp_text_core u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_req(rd_req), .rd_data(rd_data), .frame_start(frame_start),
    .scan_addr(scan_addr), .scan_data(scan_data), .busy(busy),
    .cursor_pos(cursor_pos), .cursor_vis(cursor_vis), .cursor_style(cursor_style)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int next_addr(input int a, input bit up);
    if (up) return (a == 79) ? 0 : a + 1;
    return (a == 0) ? 79 : a - 1;
  endfunction

  function automatic int exp_vis();
    if (!m_en) return 0;
    if (m_mode == 1 || m_mode == 2) return (m_fc < 32) ? 1 : 0;
    return 1;
  endfunction

  task automatic wr(input logic [3:0] i, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_idx = i; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic post_chk(input string req);
    @(negedge clk);
    chk(req, cursor_pos, m_addr);
    chk(req, cursor_vis, exp_vis());
    chk(req, cursor_style, m_mode);
  endtask

  task automatic op_data(input logic [7:0] d);
    wr(4'h9, d); mm[m_addr] = d; m_addr = next_addr(m_addr, m_up);
    post_chk("R2");
  endtask

  task automatic op_rd();
    @(negedge clk); rd_req = 1;
    @(negedge clk); rd_req = 0;
    chk("R4", rd_data, mm[m_addr]);
    m_addr = next_addr(m_addr, m_up);
    post_chk("R4");
  endtask

  task automatic op_addr(input logic [7:0] v);
    wr(4'h8, v); if (v < 80) m_addr = v;
    post_chk("R5");
  endtask

  task automatic op_dir(input bit b);
    wr(4'h3, {7'd0, b}); m_up = b;
    post_chk("R3");
  endtask

  task automatic op_curs(input logic [7:0] d);
    wr(4'h2, d); m_en = d[2]; m_mode = d[1:0];
    if (d[3]) m_addr = 0;
    post_chk("R8");
  endtask

  task automatic op_frame();
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    m_fc = (m_fc + 1) % 64;
    post_chk("R10");
  endtask

  task automatic scan_chk(input int a);
    @(negedge clk); scan_addr = 7'(a);
    @(negedge clk);
    chk("R11", scan_data, (a < 80) ? mm[a] : 0);
  endtask

  task automatic wait_fill(output int cycles);
    cycles = 0;
    while (busy && cycles < 300) begin cycles++; @(negedge clk); end
    for (int k = 0; k < 80; k++) mm[k] = 8'hA0;
    m_addr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, held_rd;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1", cursor_pos, 0); chk("R1", busy, 0);
    chk("R1", cursor_vis, 0); chk("R1", cursor_style, 0);

    // R6: clear fill length, contents and final address
    wr(4'h1, 8'h01);
    wait_fill(n);
    chk("R6", n, 80);
    chk("R6", cursor_pos, 0);
    for (int a = 0; a < 80; a++) scan_chk(a);

    // R1: default direction is up; R2 basic write
    op_data(8'h41);
    chk("R1", m_addr, 1);
    // R3 wrap up and down
    op_addr(8'd79); op_data(8'h11);
    chk("R3", cursor_pos, 0);
    op_dir(0); op_data(8'h22);
    chk("R3", cursor_pos, 79);
    op_rd();
    op_dir(1);
    // R5 out-of-range loads ignored
    op_addr(8'd85); op_addr(8'd200); op_addr(8'd80);
    // R8 home keeps RAM
    op_addr(8'd40); op_data(8'h5A);
    op_curs(8'h0D);
    scan_chk(40); scan_chk(0);
    // R10 blink across a full cycle
    for (int f = 0; f < 70; f++) op_frame();
    op_curs(8'h06);
    for (int f = 0; f < 66; f++) op_frame();
    op_curs(8'h04);
    for (int f = 0; f < 40; f++) op_frame();
    // R9 disabled cursor stays hidden
    op_curs(8'h01);
    for (int f = 0; f < 40; f++) op_frame();

    // R7 host traffic ignored during a fill
    op_addr(8'd33); op_rd(); held_rd = rd_data;
    wr(4'h1, 8'h01);
    wr(4'h9, 8'h55); wr(4'h8, 8'd12); wr(4'h3, 8'h00); wr(4'h2, 8'h08);
    @(negedge clk); rd_req = 1; @(negedge clk); rd_req = 0;
    chk("R7", busy, 1);
    chk("R7", cursor_pos, m_addr);
    chk("R7", rd_data, held_rd);
    wait_fill(n);
    chk("R7", cursor_pos, 0);
    op_data(8'h77);
    chk("R7", cursor_pos, 1);
    for (int a = 0; a < 80; a++) scan_chk(a);

    // random mix
    for (int i = 0; i < 500; i++) begin
      case ($urandom_range(0, 6))
        0, 1: op_data(8'($urandom));
        2:    op_rd();
        3:    op_addr(8'($urandom_range(0, 120)));
        4:    op_dir(1'($urandom));
        5:    op_curs(8'($urandom_range(0, 15)) & (($urandom_range(0, 3) == 0) ? 8'h0F : 8'h07));
        default: op_frame();
      endcase
    end
    for (int a = 0; a < 80; a++) scan_chk(a);
    scan_chk(100); scan_chk(127);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule